// File: doc/BRIEF.md
# Time-Mark Pulse Generator with Feedback Delay Measurement

This block emits a single time-mark pulse a programmed number of enabled clock counts after a periodic measurement tick. It then measures how long the pulse takes to travel through external line drivers and return on a feedback input. The host loads a delay value as two halves. A write to the lower half arms the generator. On the next tick the delay is counted down, and on expiry the pulse goes out while a propagation counter starts. The first rising feedback edge stops that counter and raises an acknowledge flag.

Arming, countdown, measurement and re-enable form a fixed handshake. After a pulse the generator stays locked until the host has read the status and then read the measured delay. A stuck driver, a missing feedback path or an out-of-order host access therefore leaves state the host can see: the acknowledge flag stays low, the counter sits at its ceiling, the error flag is raised, or the generator never reports ready again. All counts advance only on a clock-enable strobe, nominally 20 MHz, so each count is 50 ns.

Top module: `timemark_gen`

## Requirements
- R1: After reset `mark_out` is 0, `fb_ack` is 0, `arm_err` is 0, `prop_delay` is 0 and `gen_ready` is 1.
- R2: A `wr_lo` strobe while `gen_ready` is 1 arms the generator and drops `gen_ready`. The delay used is {upper half, lower half}, where the upper half is whatever `wr_hi` last stored.
- R3: Countdown starts only at a `tick` seen while armed. A tick while not armed has no effect, and a tick during the countdown does not reload it. With delay D, `mark_out` rises on the (D+1)-th enabled count after the tick.
- R4: The countdown, the pulse width and the propagation counter advance only on clock edges where `cnt_en` is 1.
- R5: `mark_out` stays high for exactly PULSE_LEN enabled counts (20 by default).
- R6: `prop_delay` clears when the mark rises and then counts enabled edges. It stops at the first rising edge of `fb_in`, so it holds the number of enabled edges before that edge.
- R7: That feedback edge sets `fb_ack`. Later feedback edges leave `prop_delay` unchanged.
- R8: With no feedback, `prop_delay` saturates at all ones and stays there, and `fb_ack` stays 0.
- R9: A `rd_status` strobe clears `fb_ack` and `arm_err`. A `rd_prop` strobe issued before a status read that follows the measurement leaves `gen_ready` at 0.
- R10: A `rd_prop` strobe after the measurement has ended and the status has been read sets `gen_ready` to 1.
- R11: A `wr_lo` strobe while `gen_ready` is 0 is ignored, so the armed delay is kept. It sets `arm_err`, which stays set until a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable strobe, one per 50 ns unit |
| tick | input | 1 | Measurement tick pulse |
| wr_hi | input | 1 | Write strobe for the upper delay half |
| wr_lo | input | 1 | Write strobe for the lower delay half; arms the generator |
| wr_data | input | HALF_W | Delay half written by either strobe |
| rd_status | input | 1 | Status read strobe; clears the flags and releases protection |
| rd_prop | input | 1 | Propagation-delay read strobe; re-enables the generator |
| fb_in | input | 1 | Feedback of the time mark from the external drivers |
| mark_out | output | 1 | Time-mark pulse |
| fb_ack | output | 1 | Feedback acknowledge flag |
| arm_err | output | 1 | Sticky flag for a rejected arm write |
| gen_ready | output | 1 | Generator enabled and ready to accept an arm write |
| prop_delay | output | PROP_W | Measured propagation delay in enabled counts |

## Verification
A wrong countdown load or decrement moves the rising edge of `mark_out` off D+1 enabled counts after the tick, and this shows on the very first pulse. A wrong pulse-width counter changes the high time away from 20 counts within that same pulse. Faults in the measurement path appear as a wrong `prop_delay` or `fb_ack` at the end of the measurement window. A handshake state that is wrong shows as `gen_ready` or `arm_err` out of step within one strobe of the host access that should have changed it.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic [2:0] {
    ST_READY,
    ST_ARMED,
    ST_COUNT,
    ST_MEAS,
    ST_DONE
  } tm_state_e;

  // Enabled counts from the tick to the rising edge of the mark
  function automatic int unsigned mark_latency(input int unsigned delay);
    return delay + 1;
  endfunction
endpackage

// File: rtl/tm_delay_regs.sv
module tm_delay_regs #(
  parameter int HALF_W = 16,
  localparam int DELAY_W = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic [HALF_W-1:0]  wr_data,
  input  logic               accept,
  output logic [DELAY_W-1:0] delay,
  output logic               arm_pulse,
  output logic               reject_pulse
);
  logic [HALF_W-1:0] hi_q, lo_q;

  assign arm_pulse    = wr_lo & accept;
  assign reject_pulse = wr_lo & ~accept;
  assign delay        = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi)     hi_q <= wr_data;
      if (arm_pulse) lo_q <= wr_data;
    end
  end

  // R11: a rejected write leaves the stored lower half untouched
  a_r11_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
    reject_pulse |=> $stable(lo_q));
endmodule

// File: rtl/tm_countdown.sv
module tm_countdown #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         cnt_en,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  assign expire = run & cnt_en & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (load)                             cnt_q <= load_val;
    else if (run && cnt_en && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // R4: no progress without the enable
  a_r4_cd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cnt_en) |=> $stable(cnt_q));
endmodule

// File: rtl/tm_pulse.sv
module tm_pulse #(
  parameter int LEN = 20,
  localparam int PW_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cnt_en,
  output logic mark
);
  logic [PW_W-1:0] pw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark <= 1'b0;
      pw_q <= '0;
    end else if (start) begin
      mark <= 1'b1;
      pw_q <= '0;
    end else if (mark && cnt_en) begin
      if (pw_q == PW_W'(LEN - 1)) mark <= 1'b0;
      else                        pw_q <= pw_q + 1'b1;
    end
  end

  // R5: the width counter never passes the programmed length
  a_r5_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> (int'(pw_q) < LEN));
  // R5: the pulse cannot end on an edge without the enable
  a_r5_fall_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mark) |-> $past(cnt_en));
endmodule

// File: rtl/tm_prop_counter.sv
module tm_prop_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         active,
  input  logic         fb_rise,
  input  logic         cnt_en,
  output logic [W-1:0] value,
  output logic         sat
);
  assign sat = &value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       value <= '0;
    else if (start)                                   value <= '0;
    else if (active && !fb_rise && cnt_en && !sat)    value <= value + 1'b1;
  end

  // R8: once at the ceiling the count stays there until a new start
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !start) |=> sat);
  // R6: the counter only moves while measuring or when started
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(value));
endmodule

// File: rtl/timemark_gen.sv
module timemark_gen #(
  parameter int HALF_W    = 16,
  parameter int PROP_W    = 32,
  parameter int PULSE_LEN = 20,
  localparam int DELAY_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              tick,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              rd_status,
  input  logic              rd_prop,
  input  logic              fb_in,
  output logic              mark_out,
  output logic              fb_ack,
  output logic              arm_err,
  output logic              gen_ready,
  output logic [PROP_W-1:0] prop_delay
);
  import tm_pkg::*;

  tm_state_e state_q, state_d;
  logic [DELAY_W-1:0] delay;
  logic arm_pulse, reject_pulse;
  logic cd_load, cd_expire;
  logic fb_q, fb_rise;
  logic prop_sat, meas_active;
  logic released_q;
  logic ack_q, err_q;

  assign gen_ready   = (state_q == ST_READY);
  assign cd_load     = (state_q == ST_ARMED) && tick;
  assign meas_active = (state_q == ST_MEAS);
  assign fb_rise     = fb_in & ~fb_q;
  assign fb_ack      = ack_q;
  assign arm_err     = err_q;

  tm_delay_regs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .accept(gen_ready), .delay(delay), .arm_pulse(arm_pulse),
    .reject_pulse(reject_pulse)
  );

  tm_countdown #(.W(DELAY_W)) u_cd (
    .clk(clk), .rst_n(rst_n), .load(cd_load), .load_val(delay),
    .run(state_q == ST_COUNT), .cnt_en(cnt_en), .expire(cd_expire)
  );

  tm_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(cd_expire), .cnt_en(cnt_en), .mark(mark_out)
  );

  tm_prop_counter #(.W(PROP_W)) u_prop (
    .clk(clk), .rst_n(rst_n), .start(cd_expire), .active(meas_active),
    .fb_rise(fb_rise), .cnt_en(cnt_en), .value(prop_delay), .sat(prop_sat)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_READY: if (arm_pulse) state_d = ST_ARMED;
      ST_ARMED: if (tick)      state_d = ST_COUNT;
      ST_COUNT: if (cd_expire) state_d = ST_MEAS;
      ST_MEAS:  if (fb_rise || prop_sat) state_d = ST_DONE;
      ST_DONE:  if (rd_prop && released_q) state_d = ST_READY;
      default:  state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_READY;
      fb_q       <= 1'b0;
      released_q <= 1'b0;
      ack_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      fb_q    <= fb_in;
      if (meas_active && fb_rise) ack_q <= 1'b1;
      else if (rd_status)         ack_q <= 1'b0;
      if (reject_pulse)           err_q <= 1'b1;
      else if (rd_status)         err_q <= 1'b0;
      if (state_q == ST_DONE && rd_status)    released_q <= 1'b1;
      else if (state_d == ST_READY)           released_q <= 1'b0;
    end
  end

  // R3: the mark only rises when the countdown expired the edge before
  a_r3_mark_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mark_out) |-> $past(cd_expire));
  // R7: acknowledge only follows a feedback edge
  a_r7_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_ack) |-> $past(fb_rise));
  // R7: the measured value is frozen once measurement ended
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> $stable(prop_delay));
  // R8: saturation without feedback ends with no acknowledge
  a_r8_sat_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_active && prop_sat && !fb_rise && !fb_ack) |=> !fb_ack);
  // R10: re-enable only follows a prop read after release
  a_r10_reenable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_ready) |-> ($past(rd_prop) && $past(released_q)));
  // R11: a rejected arm write raises the error flag
  a_r11_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !gen_ready) |=> arm_err);
  // R2: an accepted arm write drops ready
  a_r2_arm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && gen_ready) |=> !gen_ready);
endmodule

// File: tb/timemark_gen_tb.sv
module timemark_gen_tb;
  import tm_pkg::*;
  localparam int HALF_W = 16;
  localparam int PROP_W = 8;
  localparam int PLEN   = 20;
  localparam int PMAX   = (1 << PROP_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b1, tick = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
  logic [HALF_W-1:0] wr_data = '0;
  logic rd_status = 1'b0, rd_prop = 1'b0, fb_in = 1'b0;
  logic mark_out, fb_ack, arm_err, gen_ready;
  logic [PROP_W-1:0] prop_delay;

  int checks = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  timemark_gen #(.HALF_W(HALF_W), .PROP_W(PROP_W), .PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick), .wr_hi(wr_hi),
    .wr_lo(wr_lo), .wr_data(wr_data), .rd_status(rd_status), .rd_prop(rd_prop),
    .fb_in(fb_in), .mark_out(mark_out), .fb_ack(fb_ack), .arm_err(arm_err),
    .gen_ready(gen_ready), .prop_delay(prop_delay)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_hi(input int v);
    @(negedge clk); wr_hi = 1'b1; wr_data = HALF_W'(v);
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic strobe_lo(input int v);
    @(negedge clk); wr_lo = 1'b1; wr_data = HALF_W'(v);
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask

  task automatic read_prop();
    @(negedge clk); rd_prop = 1'b1;
    @(negedge clk); rd_prop = 1'b0;
  endtask

  // Tick, then count enabled edges to the mark, the pulse width and the delay.
  // fbn < 0 means no feedback is returned.
  task automatic run_mark(input int d, input int gap, input int fbn);
    int ens = 0, phase = 0, guard = 0, pens = 0, w = -1, limit;
    bit en;
    fb_in = 1'b0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    while (mark_out !== 1'b1 && guard < 190000) begin
      en = (phase % gap) == 0;
      cnt_en = en;
      if (en) ens++;
      phase++; guard++;
      @(negedge clk);
    end
    chk(ens == int'(mark_latency(d)), "R3 mark latency", ens, mark_latency(d));
    limit = (fbn >= 0) ? fbn + PLEN + 5 : PMAX + 40;
    while (pens < limit) begin
      if (fbn >= 0 && pens == fbn) fb_in = 1'b1;
      en = (phase % gap) == 0;
      cnt_en = en;
      if (en) pens++;
      phase++;
      @(negedge clk);
      if (w < 0 && !mark_out) w = pens;
    end
    cnt_en = 1'b1;
    chk(w == PLEN, "R5 pulse width", w, PLEN);
    if (fbn >= 0) begin
      chk(int'(prop_delay) == fbn, "R6 prop delay", prop_delay, fbn);
      chk(fb_ack == 1'b1, "R7 ack set", fb_ack, 1);
    end else begin
      chk(int'(prop_delay) == PMAX, "R8 saturated", prop_delay, PMAX);
      chk(fb_ack == 1'b0, "R8 no ack", fb_ack, 0);
    end
  endtask

  task automatic release_gen();
    read_status();
    @(negedge clk);
    chk(fb_ack == 1'b0, "R9 ack cleared", fb_ack, 0);
    read_prop();
    @(negedge clk);
    chk(gen_ready == 1'b1, "R10 re-enabled", gen_ready, 1);
    fb_in = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mark_out == 0, "R1 mark low", mark_out, 0);
    chk(fb_ack == 0, "R1 ack", fb_ack, 0);
    chk(arm_err == 0, "R1 err", arm_err, 0);
    chk(prop_delay == 0, "R1 prop", prop_delay, 0);
    chk(gen_ready == 1, "R1 ready", gen_ready, 1);

    // R3: tick while not armed does nothing
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (5) @(negedge clk);
    chk(gen_ready == 1 && mark_out == 0, "R3 idle tick ignored", mark_out, 0);

    // Delay sweep with continuous enable
    strobe_hi(0);
    for (int d = 0; d < 12; d++) begin
      strobe_lo(d);
      @(negedge clk);
      chk(gen_ready == 0, "R2 armed", gen_ready, 0);
      run_mark(d, 1, (d * 3) % 13);
      if (d == 0) begin
        read_prop();
        @(negedge clk);
        chk(gen_ready == 0, "R9 prop read before status", gen_ready, 0);
        // R7: later feedback edges do not move the value
        fb_in = 1'b0; @(negedge clk); fb_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(int'(prop_delay) == 0 && fb_ack == 1, "R7 extra edge", prop_delay, 0);
      end
      release_gen();
    end

    // R4: sparse enable
    for (int g = 2; g <= 3; g++) begin
      strobe_lo(4 + g);
      run_mark(4 + g, g, 5);
      release_gen();
    end

    // R8: no feedback
    strobe_lo(3);
    run_mark(3, 1, -1);
    release_gen();

    // R11: rejected write while armed keeps the armed delay
    strobe_lo(5);
    strobe_lo(9);
    @(negedge clk);
    chk(arm_err == 1, "R11 err set", arm_err, 1);
    run_mark(5, 1, 2);
    chk(arm_err == 1, "R11 err sticky", arm_err, 1);
    read_status();
    @(negedge clk);
    chk(arm_err == 0, "R9 err cleared", arm_err, 0);
    read_prop();
    @(negedge clk);
    chk(gen_ready == 1, "R10 ready after err", gen_ready, 1);

    // R2: upper half kept from an earlier write
    strobe_hi(1);
    strobe_lo(2);
    run_mark(65538, 1, 4);
    release_gen();
    strobe_hi(0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule